// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-transfer core of a simple 32-bit processor in which every transfer between registers crosses one shared internal bus. It holds a bank of general registers and the program counter. It also holds the memory address and memory data registers, the instruction register, an operand latch feeding the ALU and a result latch capturing the ALU output. An external sequencer, which is not part of this block, plays the control steps. In each cycle it raises one bus-drive enable and any number of load enables, and it picks an ALU function.

The ALU always takes its second operand from the bus. Its first operand is either the operand latch or the constant 4, which the sequencer uses to step the program counter. ALU results land only in the result latch, so a later step must drive that latch onto the bus to reach a destination. The sign-extended low field of the instruction register can also drive the bus, which serves immediates and branch displacements. A compare function updates the zero and negative flags and leaves every data register alone.

Word memory is reached through the memory address register (address), the memory data register (write data), pass-through read and write strobes, a read-data input and a completion input. The completion input gates the capture of read data.

Top module: `sbd_datapath`

## Requirements
- R1: After a synchronous active-high reset, every general register, PC, MAR, MDR, IR, the operand latch, the result latch and both flags hold zero.
- R2: `bus_q` equals the value of the one source whose drive enable is high: a general register, PC, MDR, the result latch or the offset field. With no drive enable high, `bus_q` is zero.
- R3: The offset source is IR bits 15..0, sign-extended from bit 15 to 32 bits.
- R4: The ALU's first operand is the constant 4 when `a_sel_four` is 1 and the operand latch otherwise. The second operand is always the bus. The result latch loads the ALU result only when `z_ld` is 1.
- R5: `alu_op` encodes the ALU function: 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 B+1, 5 ~B, 6 B shifted left by one with 0 into bit 0, 7 B passed unchanged. Sums wrap modulo 2^32.
- R6: In a cycle with `z_ld` or `cmp_en` high, the zero flag becomes (result == 0) and the negative flag becomes result bit 31. In any other cycle both flags keep their values.
- R7: A cycle with `cmp_en` high and `z_ld` low updates the flags and leaves the result latch and every general register unchanged.
- R8: MDR loads `mem_rdata` when `mdr_ld_mem` and `mem_done` are both 1. Otherwise it loads the bus when `mdr_ld_bus` is 1. With neither condition true it keeps its value.
- R9: `mem_addr` shows MAR and `mem_wdata` shows MDR. `mem_rd` and `mem_wr` follow `rd_req` and `wr_req` in the same cycle.
- R10: Any register whose load enable is high takes the bus value at the clock edge and shows it from the next cycle. This includes the case where that register also drives the bus.
- R11: At most one bus-drive enable may be high in a cycle. More than one is a protocol error that the checker reports.
- R12: Each bit of `gpr_ld` writes its own general register. Several bits high in one cycle write the same bus value into each selected register, and no other register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gpr_drv | input | 32 | Per-register bus-drive enables |
| gpr_ld | input | 32 | Per-register load enables |
| pc_drv | input | 1 | PC drives bus |
| pc_ld | input | 1 | PC loads bus |
| mar_ld | input | 1 | MAR loads bus |
| mdr_drv | input | 1 | MDR drives bus |
| mdr_ld_bus | input | 1 | MDR loads internal bus |
| mdr_ld_mem | input | 1 | MDR loads memory read data (gated by mem_done) |
| ir_ld | input | 1 | IR loads bus |
| ofs_drv | input | 1 | Sign-extended IR offset drives bus |
| y_ld | input | 1 | Operand latch loads bus |
| z_drv | input | 1 | Result latch drives bus |
| z_ld | input | 1 | Result latch loads ALU result |
| a_sel_four | input | 1 | First ALU operand is constant 4 |
| alu_op | input | 3 | ALU function code |
| cmp_en | input | 1 | Flags-only compare |
| rd_req | input | 1 | Read strobe request |
| wr_req | input | 1 | Write strobe request |
| mem_rdata | input | 32 | Memory read data |
| mem_done | input | 1 | Memory function complete |
| mem_addr | output | 32 | Memory address (MAR) |
| mem_wdata | output | 32 | Memory write data (MDR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| bus_q | output | 32 | Internal bus value |
| pc_q | output | 32 | Program counter |
| ir_q | output | 32 | Instruction register |
| flag_zero | output | 1 | Zero flag |
| flag_neg | output | 1 | Negative flag |

## Verification
The bench builds the datapath with its default widths: 32-bit data, 32 general registers and a 16-bit offset field. With these values, bit 15 of an instruction word reaches the sign extension and bit 31 of a register reaches both the negative flag and the bit lost on a left shift. Wrap-around of an addition past 2^32 is reached by adding a value with bit 31 set. Each ALU function code is exercised in turn. The bench also covers a compare against an unchanged result latch, a memory capture held back by a low completion input, both MDR load sources enabled at once, and a multi-register write.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_AND  = 3'd2,
        ALU_OR   = 3'd3,
        ALU_INC  = 3'd4,
        ALU_INV  = 3'd5,
        ALU_SHL  = 3'd6,
        ALU_PASS = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic neg;
    } flags_t;

    localparam int unsigned BUS_SRC_N = 5;
    localparam int unsigned SRC_GPR   = 0;
    localparam int unsigned SRC_PC    = 1;
    localparam int unsigned SRC_MDR   = 2;
    localparam int unsigned SRC_Z     = 3;
    localparam int unsigned SRC_OFS   = 4;

endpackage

// File: rtl/sbd_regfile.sv
module sbd_regfile #(
    parameter int unsigned W    = 32,
    parameter int unsigned NREG = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    bus,
    input  logic [NREG-1:0] ld,
    input  logic [NREG-1:0] drv,
    output logic [W-1:0]    contrib
);

    logic [W-1:0] regs  [NREG];
    logic [W-1:0] gated [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[k] <= '0;
            end else if (ld[k]) begin
                regs[k] <= bus;
            end
        end
        assign gated[k] = drv[k] ? regs[k] : '0;
    end

    always_comb begin
        contrib = '0;
        for (int k = 0; k < NREG; k++) begin
            contrib = contrib | gated[k];
        end
    end

endmodule

// File: rtl/sbd_bus.sv
module sbd_bus #(
    parameter int unsigned W    = 32,
    parameter int unsigned NSRC = 5
) (
    input  logic [NSRC-1:0][W-1:0] src,
    input  logic [NSRC-1:0]        en,
    output logic [W-1:0]           bus
);

    always_comb begin
        bus = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (en[s]) begin
                bus = bus | src[s];
            end
        end
    end

endmodule

// File: rtl/sbd_alu.sv
module sbd_alu
    import sbd_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic          a_sel_four,
    input  logic [W-1:0]  y,
    input  logic [W-1:0]  b,
    input  alu_op_e       op,
    output logic [W-1:0]  res,
    output flags_t        flg
);

    localparam logic [W-1:0] K_FOUR = W'(4);
    localparam logic [W-1:0] K_ONE  = W'(1);

    logic [W-1:0] a;

    assign a = a_sel_four ? K_FOUR : y;

    always_comb begin
        unique case (op)
            ALU_ADD:  res = a + b;
            ALU_SUB:  res = a - b;
            ALU_AND:  res = a & b;
            ALU_OR:   res = a | b;
            ALU_INC:  res = b + K_ONE;
            ALU_INV:  res = ~b;
            ALU_SHL:  res = {b[W-2:0], 1'b0};
            default:  res = b;
        endcase
    end

    assign flg.zero = (res == '0);
    assign flg.neg  = res[W-1];

endmodule

// File: rtl/sbd_datapath.sv
module sbd_datapath
    import sbd_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned NREG  = 32,
    parameter int unsigned OFS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] gpr_drv,
    input  logic [NREG-1:0] gpr_ld,
    input  logic            pc_drv,
    input  logic            pc_ld,
    input  logic            mar_ld,
    input  logic            mdr_drv,
    input  logic            mdr_ld_bus,
    input  logic            mdr_ld_mem,
    input  logic            ir_ld,
    input  logic            ofs_drv,
    input  logic            y_ld,
    input  logic            z_drv,
    input  logic            z_ld,
    input  logic            a_sel_four,
    input  logic [2:0]      alu_op,
    input  logic            cmp_en,
    input  logic            rd_req,
    input  logic            wr_req,
    input  logic [W-1:0]    mem_rdata,
    input  logic            mem_done,
    output logic [W-1:0]    mem_addr,
    output logic [W-1:0]    mem_wdata,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [W-1:0]    bus_q,
    output logic [W-1:0]    pc_q,
    output logic [W-1:0]    ir_q,
    output logic            flag_zero,
    output logic            flag_neg
);

    localparam int unsigned EXT_W = W - OFS_W;

    logic [W-1:0] pc_r, mar_r, mdr_r, ir_r, y_r, z_r;
    flags_t       flg_r;
    logic [W-1:0] bus;
    logic [W-1:0] gpr_out;
    logic [W-1:0] ofs_ext;
    logic [W-1:0] alu_res;
    flags_t       alu_flg;

    logic [BUS_SRC_N-1:0][W-1:0] bus_src;
    logic [BUS_SRC_N-1:0]        bus_en;

    sbd_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .ld      (gpr_ld),
        .drv     (gpr_drv),
        .contrib (gpr_out)
    );

    assign ofs_ext = {{EXT_W{ir_r[OFS_W-1]}}, ir_r[OFS_W-1:0]};

    always_comb begin
        bus_src          = '0;
        bus_src[SRC_GPR] = gpr_out;
        bus_src[SRC_PC]  = pc_r;
        bus_src[SRC_MDR] = mdr_r;
        bus_src[SRC_Z]   = z_r;
        bus_src[SRC_OFS] = ofs_ext;
        bus_en           = '0;
        bus_en[SRC_GPR]  = |gpr_drv;
        bus_en[SRC_PC]   = pc_drv;
        bus_en[SRC_MDR]  = mdr_drv;
        bus_en[SRC_Z]    = z_drv;
        bus_en[SRC_OFS]  = ofs_drv;
    end

    sbd_bus #(.W(W), .NSRC(BUS_SRC_N)) u_bus (
        .src (bus_src),
        .en  (bus_en),
        .bus (bus)
    );

    sbd_alu #(.W(W)) u_alu (
        .a_sel_four (a_sel_four),
        .y          (y_r),
        .b          (bus),
        .op         (alu_op_e'(alu_op)),
        .res        (alu_res),
        .flg        (alu_flg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_r  <= '0;
            mar_r <= '0;
            ir_r  <= '0;
            y_r   <= '0;
        end else begin
            if (pc_ld)  pc_r  <= bus;
            if (mar_ld) mar_r <= bus;
            if (ir_ld)  ir_r  <= bus;
            if (y_ld)   y_r   <= bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mdr_r <= '0;
        end else if (mdr_ld_mem && mem_done) begin
            mdr_r <= mem_rdata;
        end else if (mdr_ld_bus) begin
            mdr_r <= bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            z_r   <= '0;
            flg_r <= '0;
        end else begin
            if (z_ld) begin
                z_r <= alu_res;
            end
            if (z_ld || cmp_en) begin
                flg_r <= alu_flg;
            end
        end
    end

    assign mem_addr  = mar_r;
    assign mem_wdata = mdr_r;
    assign mem_rd    = rd_req;
    assign mem_wr    = wr_req;
    assign bus_q     = bus;
    assign pc_q      = pc_r;
    assign ir_q      = ir_r;
    assign flag_zero = flg_r.zero;
    assign flag_neg  = flg_r.neg;

endmodule

// File: rtl/sbd_chk.sv
module sbd_chk #(
    parameter int unsigned W    = 32,
    parameter int unsigned NREG = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [NREG-1:0] gpr_drv,
    input logic            pc_drv,
    input logic            pc_ld,
    input logic            mar_ld,
    input logic            mdr_drv,
    input logic            mdr_ld_bus,
    input logic            mdr_ld_mem,
    input logic            mem_done,
    input logic            ofs_drv,
    input logic            z_drv,
    input logic            z_ld,
    input logic            cmp_en,
    input logic [W-1:0]    mem_addr,
    input logic [W-1:0]    mem_wdata,
    input logic [W-1:0]    bus_q,
    input logic [W-1:0]    pc_q,
    input logic            flag_zero,
    input logic            flag_neg
);

    logic any_drv;
    assign any_drv = (|gpr_drv) | pc_drv | mdr_drv | ofs_drv | z_drv;

    // R11
    single_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({gpr_drv, pc_drv, mdr_drv, z_drv, ofs_drv}) <= 1);

    // R2
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !any_drv |-> (bus_q == '0));

    // R2
    pc_on_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_drv && $countones({gpr_drv, mdr_drv, z_drv, ofs_drv}) == 0) |-> (bus_q == pc_q));

    // R10
    mar_load_chk: assert property (@(posedge clk) disable iff (rst)
        mar_ld |=> (mem_addr == $past(bus_q)));

    // R10
    mar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mar_ld |=> $stable(mem_addr));

    // R10
    pc_load_chk: assert property (@(posedge clk) disable iff (rst)
        pc_ld |=> (pc_q == $past(bus_q)));

    // R8
    mdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mdr_ld_bus && !(mdr_ld_mem && mem_done)) |=> $stable(mem_wdata));

    // R6
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!z_ld && !cmp_en) |=> ($stable(flag_zero) && $stable(flag_neg)));

endmodule

bind sbd_datapath sbd_chk #(.W(W), .NREG(NREG)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .gpr_drv    (gpr_drv),
    .pc_drv     (pc_drv),
    .pc_ld      (pc_ld),
    .mar_ld     (mar_ld),
    .mdr_drv    (mdr_drv),
    .mdr_ld_bus (mdr_ld_bus),
    .mdr_ld_mem (mdr_ld_mem),
    .mem_done   (mem_done),
    .ofs_drv    (ofs_drv),
    .z_drv      (z_drv),
    .z_ld       (z_ld),
    .cmp_en     (cmp_en),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .bus_q      (bus_q),
    .pc_q       (pc_q),
    .flag_zero  (flag_zero),
    .flag_neg   (flag_neg)
);

// File: tb/sbd_datapath_tb.sv
module sbd_datapath_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] gpr_drv, gpr_ld;
    logic        pc_drv, pc_ld, mar_ld, mdr_drv, mdr_ld_bus, mdr_ld_mem;
    logic        ir_ld, ofs_drv, y_ld, z_drv, z_ld, a_sel_four, cmp_en;
    logic [2:0]  alu_op;
    logic        rd_req, wr_req, mem_done;
    logic [31:0] mem_rdata;
    logic [31:0] mem_addr, mem_wdata, bus_q, pc_q, ir_q;
    logic        mem_rd, mem_wr, flag_zero, flag_neg;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_gpr [32];
    logic [31:0] m_pc, m_mar, m_mdr, m_ir, m_y, m_z;
    logic        m_fz, m_fn;

    always #10 clk = ~clk;

    sbd_datapath dut_i (
        .clk(clk), .rst(rst), .gpr_drv(gpr_drv), .gpr_ld(gpr_ld),
        .pc_drv(pc_drv), .pc_ld(pc_ld), .mar_ld(mar_ld), .mdr_drv(mdr_drv),
        .mdr_ld_bus(mdr_ld_bus), .mdr_ld_mem(mdr_ld_mem), .ir_ld(ir_ld),
        .ofs_drv(ofs_drv), .y_ld(y_ld), .z_drv(z_drv), .z_ld(z_ld),
        .a_sel_four(a_sel_four), .alu_op(alu_op), .cmp_en(cmp_en),
        .rd_req(rd_req), .wr_req(wr_req), .mem_rdata(mem_rdata),
        .mem_done(mem_done), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_q(bus_q), .pc_q(pc_q),
        .ir_q(ir_q), .flag_zero(flag_zero), .flag_neg(flag_neg)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        gpr_drv = '0; gpr_ld = '0;
        pc_drv = 0; pc_ld = 0; mar_ld = 0; mdr_drv = 0; mdr_ld_bus = 0;
        mdr_ld_mem = 0; ir_ld = 0; ofs_drv = 0; y_ld = 0; z_drv = 0;
        z_ld = 0; a_sel_four = 0; alu_op = 3'd0; cmp_en = 0;
        rd_req = 0; wr_req = 0; mem_done = 0;
    endtask

    task automatic model_reset();
        for (int k = 0; k < 32; k++) m_gpr[k] = '0;
        m_pc = '0; m_mar = '0; m_mdr = '0; m_ir = '0; m_y = '0; m_z = '0;
        m_fz = 0; m_fn = 0;
    endtask

    // One clock of the reference model; called just after a negedge with inputs set.
    task automatic cyc(input string tag);
        logic [31:0] eb, a, r;
        int ndrv;
        #1;
        eb = '0;
        ndrv = 0;
        for (int k = 0; k < 32; k++) if (gpr_drv[k]) begin eb = m_gpr[k]; ndrv++; end
        if (pc_drv)  begin eb = m_pc; ndrv++; end
        if (mdr_drv) begin eb = m_mdr; ndrv++; end
        if (z_drv)   begin eb = m_z; ndrv++; end
        if (ofs_drv) begin eb = {{16{m_ir[15]}}, m_ir[15:0]}; ndrv++; end
        check(tag, "bus", bus_q, eb);
        check("R9", "mem_rd", {31'd0, mem_rd}, {31'd0, rd_req});
        check("R9", "mem_wr", {31'd0, mem_wr}, {31'd0, wr_req});
        a = a_sel_four ? 32'd4 : m_y;
        case (alu_op)
            3'd0: r = a + eb;
            3'd1: r = a - eb;
            3'd2: r = a & eb;
            3'd3: r = a | eb;
            3'd4: r = eb + 32'd1;
            3'd5: r = ~eb;
            3'd6: r = eb * 2;
            default: r = eb;
        endcase
        @(posedge clk);
        for (int k = 0; k < 32; k++) if (gpr_ld[k]) m_gpr[k] = eb;
        if (pc_ld)  m_pc  = eb;
        if (mar_ld) m_mar = eb;
        if (ir_ld)  m_ir  = eb;
        if (y_ld)   m_y   = eb;
        if (mdr_ld_mem && mem_done) m_mdr = mem_rdata;
        else if (mdr_ld_bus)        m_mdr = eb;
        if (z_ld) m_z = r;
        if (z_ld || cmp_en) begin
            m_fz = (r == 32'd0);
            m_fn = r[31];
        end
        @(negedge clk);
        check(tag, "pc", pc_q, m_pc);
        check(tag, "mar", mem_addr, m_mar);
        check(tag, "mdr", mem_wdata, m_mdr);
        check(tag, "ir", ir_q, m_ir);
        check("R6", "zero", {31'd0, flag_zero}, {31'd0, m_fz});
        check("R6", "neg", {31'd0, flag_neg}, {31'd0, m_fn});
        idle();
    endtask

    task automatic load_gpr(input int k, input logic [31:0] v);
        mem_rdata = v; mdr_ld_mem = 1; mem_done = 1; rd_req = 1;
        cyc("R8");
        mdr_drv = 1; gpr_ld[k] = 1;
        cyc("R10");
    endtask

    task automatic show_gpr(input int k, input string tag);
        gpr_drv[k] = 1;
        cyc(tag);
    endtask

    task automatic alu_run(input logic [2:0] op, input int ra, input int rb, input int rd);
        gpr_drv[ra] = 1; y_ld = 1;
        cyc("R4");
        gpr_drv[rb] = 1; alu_op = op; z_ld = 1;
        cyc("R5");
        z_drv = 1; gpr_ld[rd] = 1;
        cyc("R5");
        show_gpr(rd, "R5");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        mem_rdata = '0;
        rst = 1;
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1", "pc", pc_q, 32'd0);
        check("R1", "ir", ir_q, 32'd0);
        check("R1", "mar", mem_addr, 32'd0);
        check("R1", "mdr", mem_wdata, 32'd0);
        check("R1", "zero", {31'd0, flag_zero}, 32'd0);
        check("R1", "neg", {31'd0, flag_neg}, 32'd0);
        show_gpr(7, "R1");
        z_drv = 1; cyc("R1");
        cyc("R2");

        load_gpr(1, 32'h8000_0001);
        load_gpr(2, 32'h0000_00F3);
        load_gpr(4, 32'h0000_0005);
        for (int op = 0; op < 8; op++) alu_run(3'(op), 1, 2, 5 + op);
        alu_run(3'd6, 2, 1, 14);          // R5 shl drops bit 31
        alu_run(3'd0, 1, 1, 15);          // R5 wrap on add
        alu_run(3'd1, 4, 4, 16);          // R6 zero flag

        // R7: compare leaves Z and registers alone
        gpr_drv[4] = 1; y_ld = 1; cyc("R7");
        gpr_drv[2] = 1; alu_op = 3'd1; cmp_en = 1; cyc("R7");
        z_drv = 1; cyc("R7");
        show_gpr(16, "R7");
        gpr_drv[2] = 1; y_ld = 1; cyc("R7");
        gpr_drv[2] = 1; alu_op = 3'd1; cmp_en = 1; cyc("R7");

        // R4: PC steps by the constant 4
        for (int i = 0; i < 2; i++) begin
            pc_drv = 1; a_sel_four = 1; alu_op = 3'd0; z_ld = 1; mar_ld = 1; rd_req = 1;
            cyc("R4");
            z_drv = 1; pc_ld = 1;
            cyc("R4");
        end

        // R8: capture held until completion
        mem_rdata = 32'hABCD_8005; mdr_ld_mem = 1; mem_done = 0; rd_req = 1;
        cyc("R8");
        mdr_ld_mem = 1; mem_done = 1; rd_req = 1;
        cyc("R8");
        // R3: negative offset
        mdr_drv = 1; ir_ld = 1; cyc("R3");
        ofs_drv = 1; gpr_ld[20] = 1; cyc("R3");
        show_gpr(20, "R3");
        // R10: branch by displacement
        pc_drv = 1; y_ld = 1; cyc("R10");
        ofs_drv = 1; alu_op = 3'd0; z_ld = 1; cyc("R10");
        z_drv = 1; pc_ld = 1; cyc("R10");
        pc_drv = 1; pc_ld = 1; cyc("R10");
        // R3: positive offset
        mem_rdata = 32'h7777_1234; mdr_ld_mem = 1; mem_done = 1; cyc("R8");
        mdr_drv = 1; ir_ld = 1; cyc("R3");
        ofs_drv = 1; cyc("R3");

        // R9: store path
        gpr_drv[2] = 1; mar_ld = 1; cyc("R9");
        gpr_drv[1] = 1; mdr_ld_bus = 1; cyc("R9");
        wr_req = 1; cyc("R9");

        // R8: both MDR sources
        mem_rdata = 32'h1357_9BDF;
        gpr_drv[4] = 1; mdr_ld_bus = 1; mdr_ld_mem = 1; mem_done = 1; cyc("R8");
        gpr_drv[4] = 1; mdr_ld_bus = 1; mdr_ld_mem = 1; mem_done = 0; cyc("R8");

        // R12: multi-register write
        mdr_drv = 1; gpr_ld[30] = 1; gpr_ld[31] = 1; cyc("R12");
        show_gpr(30, "R12");
        show_gpr(31, "R12");
        show_gpr(29, "R12");
        show_gpr(1, "R12");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule